// File: doc/BRIEF.md
# Link Channel Control and Sticky Status Registers

This block is the management-side register slice of one serial link channel. Software writes a control word whose reset bits fire a single-cycle reset pulse into the channel and then fall back to zero on their own. It reads a status word whose bits capture transient datapath conditions: loss of signal, FIFO overflow and underflow, decoder errors, and drops in lock, sync and link state. Each captured value is held until the status word is read.

Each status bit has one of three capture rules. A rising-event bit holds a one once its live input has been high. A falling-event bit holds a zero once its live input has been low. One bit simply follows its input through a register. A read hands back the captured value and reloads the bit from the live input in that same cycle, so an event that coincides with the read is never lost. A third register counts decoder-invalid cycles while the channel is in functional mode. The count saturates at all ones and clears when read.

Register access is a single-cycle port on the management clock. `reg_rdata` is combinational from the current register contents whenever `reg_rd` is high, and it is zero otherwise. Addresses: control 0x0E, status 0x0F, error count 0x10.

Top module: `lnk_mgmt_regs`

## Requirements
- R1: A write to 0x0E sets the reset outputs one cycle later, for exactly one cycle. Bit 3 drives both `tx_dp_rst` and `rx_dp_rst`, bit 2 drives `tx_fifo_rst` and bit 1 drives `rx_fifo_rst`.
- R2: Every control bit returns to zero in the cycle after it was set, unless it is written again. A read of 0x0E returns the control bits at positions 3..1 and zero elsewhere.
- R3: A channel reset pulse leaves the status and error-count registers unchanged.
- R4: Status bits 13, 9, 8, 7, 6, 5 and 4 capture a high level of the matching `stat_live` bit and hold it until the status word is read. Bits 7..4 are transmit FIFO underflow, transmit FIFO overflow, receive FIFO underflow and receive FIFO overflow.
- R5: Status bits 14, 12, 11, 10, 3, 2, 1 and 0 capture a low level of the matching `stat_live` bit and hold it until the status word is read. Bit 1 is low-speed PLL lock and bit 0 is high-speed PLL lock.
- R6: Status bit 15 returns the value `stat_live[15]` had one cycle earlier. After reset, every register and every output is zero.
- R7: A read of 0x0F returns the held status. On the next cycle each bit takes the `stat_live` value present during the read cycle, so an event in the read cycle stays captured.
- R8: The error count at 0x10 increases by one for each cycle in which `stat_live[8]` and `func_mode` are both high. It does not change when `func_mode` is low.
- R9: The error count saturates at all ones and clears on a read of 0x10. An event in the read cycle leaves a count of one.
- R10: Writes to 0x0F and 0x10 have no effect. Reads of any other address return zero, and `reg_rdata` is zero whenever `reg_rd` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | management clock |
| rst_n | input | 1 | active-low asynchronous reset |
| reg_wr | input | 1 | register write strobe |
| reg_rd | input | 1 | register read strobe |
| reg_addr | input | ADDR_W | register address |
| reg_wdata | input | 16 | write data |
| reg_rdata | output | 16 | read data, zero when not reading |
| stat_live | input | 16 | live status inputs, one per status bit |
| func_mode | input | 1 | channel in functional mode, enables error counting |
| tx_dp_rst | output | 1 | transmit datapath reset pulse |
| rx_dp_rst | output | 1 | receive datapath reset pulse |
| tx_fifo_rst | output | 1 | transmit FIFO reset pulse |
| rx_fifo_rst | output | 1 | receive FIFO reset pulse |

## Verification
The bench builds the block with `CNT_W` = 4, so the error count saturates at 15. Saturation, holding at the ceiling, and clearing from the ceiling can then be reached within a few dozen cycles. `ADDR_W` keeps its default of 5, which leaves addresses outside the map reachable for the read-zero checks. The counter width changes only the ceiling: the capture rules and the pulse timing are identical for every width.

// File: rtl/lnk_regs_pkg.sv
package lnk_regs_pkg;

  localparam int STAT_W = 16;

  // capture class per status bit
  localparam logic [STAT_W-1:0] LH_MASK    = 16'h23F0;
  localparam logic [STAT_W-1:0] LL_MASK    = 16'h5C0F;
  localparam logic [STAT_W-1:0] PLAIN_MASK = 16'h8000;

  // control bit positions (decoded by the datapath reset fan-out)
  localparam int CB_CHAN = 3;
  localparam int CB_TXF  = 2;
  localparam int CB_RXF  = 1;
  localparam int CB_LO   = 1;
  localparam int CB_HI   = 3;

  typedef enum logic [1:0] {
    LK_PLAIN = 2'd0,
    LK_HIGH  = 2'd1,
    LK_LOW   = 2'd2
  } latch_kind_e;

  function automatic latch_kind_e kind_of(int b);
    if (LH_MASK[b])      return LK_HIGH;
    else if (LL_MASK[b]) return LK_LOW;
    else                 return LK_PLAIN;
  endfunction

  // next value of one captured bit
  function automatic logic latch_next(latch_kind_e k, logic q, logic live, logic clr);
    logic n;
    case (k)
      LK_HIGH: n = clr ? live : (q | live);
      LK_LOW:  n = clr ? live : (q & live);
      default: n = live;
    endcase
    return n;
  endfunction

  // next value of a saturating, clear-on-read counter
  function automatic logic [31:0] cnt_next(logic [31:0] cur, logic [31:0] top,
                                           logic evt, logic clr);
    logic [31:0] n;
    if (clr)                    n = evt ? 32'd1 : 32'd0;
    else if (evt && cur != top) n = cur + 32'd1;
    else                        n = cur;
    return n;
  endfunction

endpackage

// File: rtl/lnk_sc_ctrl.sv
module lnk_sc_ctrl
  import lnk_regs_pkg::*;
(
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  wr_en,
  input  logic [CB_HI:CB_LO]    wbits,
  output logic [CB_HI:CB_LO]    ctrl_q
);
  // each bit lives for one cycle unless rewritten
  for (genvar b = CB_LO; b <= CB_HI; b++) begin : g_sc
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) ctrl_q[b] <= 1'b0;
      else        ctrl_q[b] <= wr_en & wbits[b];
    end
  end
endmodule

// File: rtl/lnk_stat_latch.sv
module lnk_stat_latch
  import lnk_regs_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd_clr,
  input  logic [STAT_W-1:0] live,
  output logic [STAT_W-1:0] stat_q
);
  for (genvar b = 0; b < STAT_W; b++) begin : g_bit
    localparam latch_kind_e KIND = kind_of(b);
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stat_q[b] <= 1'b0;
      else        stat_q[b] <= latch_next(KIND, stat_q[b], live[b], rd_clr);
    end
  end
endmodule

// File: rtl/lnk_err_cnt.sv
module lnk_err_cnt
  import lnk_regs_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             evt,
  input  logic             rd_clr,
  output logic [CNT_W-1:0] cnt_q
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic [31:0] nxt;
  assign nxt = cnt_next(32'(cnt_q), 32'(CNT_MAX), evt, rd_clr);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= nxt[CNT_W-1:0];
  end
endmodule

// File: rtl/lnk_mgmt_regs.sv
module lnk_mgmt_regs
  import lnk_regs_pkg::*;
#(
  parameter int ADDR_W    = 5,
  parameter int CNT_W     = 16,
  parameter int CTRL_ADDR = 14,
  parameter int STAT_ADDR = 15,
  parameter int ERRC_ADDR = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [15:0]       reg_wdata,
  output logic [15:0]       reg_rdata,
  input  logic [15:0]       stat_live,
  input  logic              func_mode,
  output logic              tx_dp_rst,
  output logic              rx_dp_rst,
  output logic              tx_fifo_rst,
  output logic              rx_fifo_rst
);
  localparam int DATA_W = 16;
  localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(CTRL_ADDR);
  localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(STAT_ADDR);
  localparam logic [ADDR_W-1:0] A_ERRC = ADDR_W'(ERRC_ADDR);

  // named internal events
  logic                 wr_ctrl, rd_ctrl, rd_stat, rd_cnt, cnt_evt;
  logic [CB_HI:CB_LO]   ctrl_q;
  logic [STAT_W-1:0]    stat_q;
  logic [CNT_W-1:0]     cnt_q;
  logic [DATA_W-1:0]    ctrl_word, cnt_word;

  assign wr_ctrl = reg_wr && (reg_addr == A_CTRL);
  assign rd_ctrl = reg_rd && (reg_addr == A_CTRL);
  assign rd_stat = reg_rd && (reg_addr == A_STAT);
  assign rd_cnt  = reg_rd && (reg_addr == A_ERRC);
  assign cnt_evt = func_mode && stat_live[8];

  lnk_sc_ctrl u_ctrl (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr_en  (wr_ctrl),
    .wbits  (reg_wdata[CB_HI:CB_LO]),
    .ctrl_q (ctrl_q)
  );

  lnk_stat_latch u_stat (
    .clk    (clk),
    .rst_n  (rst_n),
    .rd_clr (rd_stat),
    .live   (stat_live),
    .stat_q (stat_q)
  );

  lnk_err_cnt #(.CNT_W(CNT_W)) u_cnt (
    .clk    (clk),
    .rst_n  (rst_n),
    .evt    (cnt_evt),
    .rd_clr (rd_cnt),
    .cnt_q  (cnt_q)
  );

  // reset fan-out: the channel bit hits both directions
  assign tx_dp_rst   = ctrl_q[CB_CHAN];
  assign rx_dp_rst   = ctrl_q[CB_CHAN];
  assign tx_fifo_rst = ctrl_q[CB_TXF];
  assign rx_fifo_rst = ctrl_q[CB_RXF];

  always_comb begin
    ctrl_word = '0;
    ctrl_word[CB_HI:CB_LO] = ctrl_q;
  end
  assign cnt_word = DATA_W'(cnt_q);

  always_comb begin
    reg_rdata = '0;
    if (rd_ctrl)      reg_rdata = ctrl_word;
    else if (rd_stat) reg_rdata = stat_q;
    else if (rd_cnt)  reg_rdata = cnt_word;
  end

  logic unused_wdata;
  assign unused_wdata = ^{reg_wdata[15:CB_HI+1], reg_wdata[CB_LO-1:0]};
endmodule

// File: rtl/lnk_regs_chk.sv
module lnk_regs_chk
  import lnk_regs_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input logic               clk,
  input logic               rst_n,
  input logic               wr_ctrl,
  input logic [15:0]        reg_wdata,
  input logic [CB_HI:CB_LO] ctrl_q,
  input logic               rd_stat,
  input logic [STAT_W-1:0]  stat_q,
  input logic [STAT_W-1:0]  stat_live,
  input logic               rd_cnt,
  input logic               cnt_evt,
  input logic [CNT_W-1:0]   cnt_q
);
  localparam logic [CNT_W-1:0] CMAX = '1;

  AST_WRITE_FIRES: assert property (@(posedge clk) disable iff (!rst_n)
    wr_ctrl |=> (ctrl_q == $past(reg_wdata[CB_HI:CB_LO]))); // R1

  AST_SELF_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_ctrl |=> (ctrl_q == '0)); // R2

  AST_HIGH_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_stat |=> ((stat_q & $past(stat_q) & LH_MASK) == ($past(stat_q) & LH_MASK))); // R4

  AST_LOW_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_stat |=> (((stat_q | $past(stat_q)) & LL_MASK) == ($past(stat_q) & LL_MASK))); // R5

  AST_READ_RELOADS: assert property (@(posedge clk) disable iff (!rst_n)
    rd_stat |=> (stat_q == $past(stat_live))); // R7

  AST_CNT_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (!rd_cnt && !cnt_evt) |=> $stable(cnt_q)); // R8

  AST_CNT_CEILING: assert property (@(posedge clk) disable iff (!rst_n)
    (!rd_cnt && cnt_q == CMAX) |=> (cnt_q == CMAX)); // R9

  AST_CNT_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_cnt && !cnt_evt) |=> (cnt_q == '0)); // R9
endmodule

bind lnk_mgmt_regs lnk_regs_chk #(.CNT_W(CNT_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .wr_ctrl   (wr_ctrl),
  .reg_wdata (reg_wdata),
  .ctrl_q    (ctrl_q),
  .rd_stat   (rd_stat),
  .stat_q    (stat_q),
  .stat_live (stat_live),
  .rd_cnt    (rd_cnt),
  .cnt_evt   (cnt_evt),
  .cnt_q     (cnt_q)
);

// File: tb/tb_lnk_mgmt_regs.sv
module tb_lnk_mgmt_regs;
  localparam int CLK_PERIOD = 10;
  localparam int TB_CNT_W   = 4;
  localparam int CMAX       = (1 << TB_CNT_W) - 1;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0, reg_rd = 1'b0, func_mode = 1'b0;
  logic [4:0]  reg_addr = '0;
  logic [15:0] reg_wdata = '0, stat_live = '0;
  logic [15:0] reg_rdata;
  logic        tx_dp_rst, rx_dp_rst, tx_fifo_rst, rx_fifo_rst;

  int checks = 0, errors = 0;
  bit done = 0;
  string cur_req = "R6";

  // reference state
  bit [15:0] m_stat = '0;
  bit [3:1]  m_ctrl = '0;
  int        m_cnt  = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  lnk_mgmt_regs #(.CNT_W(TB_CNT_W)) dut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .stat_live(stat_live), .func_mode(func_mode),
    .tx_dp_rst(tx_dp_rst), .rx_dp_rst(rx_dp_rst),
    .tx_fifo_rst(tx_fifo_rst), .rx_fifo_rst(rx_fifo_rst)
  );

  function automatic bit rises_kept(int b);
    return (b == 13) || (b >= 4 && b <= 9);
  endfunction

  task automatic chk(string req, string what, logic [15:0] act, logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h at %0t", req, what, act, exp, $time);
    end
  endtask

  task automatic step(bit wr, bit rd, int addr, logic [15:0] wd, logic [15:0] live, bit fm);
    logic [15:0] exp_rd;
    bit ev;
    @(negedge clk);
    reg_wr = wr; reg_rd = rd; reg_addr = addr[4:0]; reg_wdata = wd;
    stat_live = live; func_mode = fm;
    #1;
    exp_rd = 16'h0;
    if (rd) begin
      if (addr == 14)      exp_rd = {12'h0, m_ctrl, 1'b0};
      else if (addr == 15) exp_rd = m_stat;
      else if (addr == 16) exp_rd = 16'(m_cnt);
    end
    chk(cur_req, "rdata", reg_rdata, exp_rd);
    chk(cur_req, "resets", {12'h0, tx_dp_rst, rx_dp_rst, tx_fifo_rst, rx_fifo_rst},
        {12'h0, m_ctrl[3], m_ctrl[3], m_ctrl[2], m_ctrl[1]});
    @(posedge clk);
    ev = fm && live[8];
    for (int b = 0; b < 16; b++) begin
      if (b == 15 || (rd && addr == 15)) m_stat[b] = live[b];
      else if (rises_kept(b))            m_stat[b] = m_stat[b] | live[b];
      else                               m_stat[b] = m_stat[b] & live[b];
    end
    m_ctrl = (wr && addr == 14) ? wd[3:1] : 3'b000;
    if (rd && addr == 16)         m_cnt = ev ? 1 : 0;
    else if (ev && m_cnt < CMAX)  m_cnt = m_cnt + 1;
  endtask

  task automatic idle(int n, logic [15:0] live, bit fm);
    for (int i = 0; i < n; i++) step(0, 0, 0, 16'h0, live, fm);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    // R6: reset state
    repeat (3) @(posedge clk);
    #1;
    chk("R6", "rdata in reset", reg_rdata, 16'h0);
    chk("R6", "resets in reset", {12'h0, tx_dp_rst, rx_dp_rst, tx_fifo_rst, rx_fifo_rst}, 16'h0);
    @(negedge clk); rst_n = 1'b1;
    step(0, 1, 15, 0, 16'h0, 0);
    step(0, 1, 16, 0, 16'h0, 0);
    step(0, 1, 15, 0, 16'h8000, 0);
    step(0, 1, 15, 0, 16'h0000, 0);   // bit 15 seen one cycle late

    // R1 R2: each reset bit pulses once, read back during the pulse
    cur_req = "R1";
    step(1, 0, 14, 16'h0008, 16'h0, 0);
    step(0, 1, 14, 0, 16'h0, 0);
    idle(2, 16'h0, 0);
    step(1, 0, 14, 16'h0004, 16'h0, 0);
    step(1, 0, 14, 16'h0002, 16'h0, 0);
    cur_req = "R2";
    step(0, 1, 14, 0, 16'h0, 0);
    step(0, 1, 14, 0, 16'h0, 0);
    step(1, 0, 14, 16'hFFFF, 16'h0, 0);
    step(1, 1, 14, 16'h000E, 16'h0, 0);
    step(0, 1, 14, 0, 16'h0, 0);
    step(0, 1, 14, 0, 16'h0, 0);

    // R5: falling-event bits, PLL locks in bits 1 and 0
    cur_req = "R5";
    step(0, 1, 15, 0, 16'h5C0F, 0);
    step(0, 1, 15, 0, 16'h5C0F, 0);
    step(0, 0, 0, 0, 16'h5C0E, 0);
    idle(2, 16'h5C0F, 0);
    step(0, 1, 15, 0, 16'h5C0F, 0);
    step(0, 1, 15, 0, 16'h5C0F, 0);
    step(0, 0, 0, 0, 16'h1C0D, 0);
    step(0, 1, 15, 0, 16'h5C0F, 0);

    // R4: rising-event bits, FIFO flags in bits 7..4
    cur_req = "R4";
    step(0, 0, 0, 0, 16'h5C4F, 0);
    idle(3, 16'h5C0F, 0);
    step(0, 1, 15, 0, 16'h5C0F, 0);
    step(0, 1, 15, 0, 16'h5C0F, 0);
    step(0, 0, 0, 0, 16'h7F9F, 0);
    step(0, 1, 15, 0, 16'h5C0F, 0);
    step(0, 1, 15, 0, 16'h5C0F, 0);

    // R7: event in the read cycle survives
    cur_req = "R7";
    step(0, 1, 15, 0, 16'h5C2F, 0);
    step(0, 1, 15, 0, 16'h5C0F, 0);
    step(0, 1, 15, 0, 16'h5C0B, 0);
    step(0, 1, 15, 0, 16'h5C0F, 0);

    // R8: counting gated by functional mode
    cur_req = "R8";
    step(0, 1, 16, 0, 16'h0, 0);
    idle(3, 16'h0100, 1);
    idle(2, 16'h0100, 0);
    step(0, 1, 16, 0, 16'h0, 0);
    step(0, 1, 16, 0, 16'h0, 0);

    // R3: channel reset leaves status and count alone
    cur_req = "R3";
    idle(2, 16'h0110, 1);
    step(1, 0, 14, 16'h000E, 16'h5C0F, 0);
    idle(2, 16'h5C0F, 0);
    step(0, 1, 16, 0, 16'h5C0F, 0);
    step(0, 1, 15, 0, 16'h5C0F, 0);

    // R9: saturation and clear-on-read
    cur_req = "R9";
    idle(CMAX + 5, 16'h0100, 1);
    step(0, 1, 16, 0, 16'h0, 1);
    step(0, 1, 16, 0, 16'h0, 1);
    idle(CMAX + 2, 16'h0100, 1);
    step(0, 1, 16, 0, 16'h0100, 1);
    step(0, 1, 16, 0, 16'h0, 1);

    // R10: ignored writes, unmapped and idle reads
    cur_req = "R10";
    step(0, 1, 15, 0, 16'h0, 0);
    step(1, 0, 15, 16'hFFFF, 16'h0, 0);
    step(1, 0, 16, 16'hFFFF, 16'h0, 0);
    step(0, 1, 15, 0, 16'h0, 0);
    step(0, 1, 16, 0, 16'h0, 0);
    step(0, 1, 17, 0, 16'hFFFF, 1);
    step(0, 1, 13, 0, 16'hFFFF, 1);
    step(0, 0, 15, 0, 16'hFFFF, 1);

    // mixed traffic against the reference
    cur_req = "R4/R5/R7/R8/R9";
    for (int i = 0; i < 400; i++) begin
      int a;
      a = 13 + ($urandom % 5);
      step(($urandom % 6) == 0, ($urandom % 3) == 0, a, 16'($urandom),
           16'($urandom), ($urandom % 4) != 0);
    end

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule